// File: doc/BRIEF.md
# Repetition Code Secure Sketch

This block turns a noisy binary response into helper data and later recovers one key bit from a fresh, noisy reading of the same source. A code word is N bits long, with N odd and a default of 7. For each position above zero, the helper bit is bit zero XOR that position's bit. Storing these N-1 helper bits reveals how the bits relate to one another, but not the value of bit zero itself.

For recovery, the fresh readout is combined with the stored helper bits. Each position gives its own estimate of the enrolled bit zero, and the key bit is the majority of those N estimates. The block also reports the error pattern. XORing that pattern into the fresh readout gives back the enrolled response whenever no more than (N-1)/2 bits have flipped. The same response port feeds both the helper generator and the recovery path, so one evaluation serves enrollment and reconstruction alike.

The arithmetic is purely combinational. A parameter chooses between a registered output stage with a valid flag and a direct combinational pass-through.

Top module: `rep_sketch`

## Requirements
- R1: `helper_out[i]` equals `resp_in[0] ^ resp_in[i+1]` for every i from 0 to N-2.
- R2: `key_bit` is 1 exactly when at least (N+1)/2 of the N estimates are 1. Estimate 0 is `resp_in[0]`, and estimate i (i ≥ 1) is `resp_in[i] ^ helper_in[i-1]`.
- R3: `err_pat[0]` is 1 exactly when the syndrome, whose bit i-1 is `resp_in[0] ^ resp_in[i] ^ helper_in[i-1]`, has a weight of at least (N+1)/2.
- R4: For i ≥ 1, `err_pat[i]` equals `err_pat[0]` XOR syndrome bit i-1.
- R5: If the readout differs from an enrolled word in at most (N-1)/2 positions, and `helper_in` was produced from that word, then `err_pat` equals the flip pattern and `key_bit` equals the enrolled bit zero. With more flips, the outputs name the complement pattern and the complement bit.
- R6: With REG_OUT=1, the outputs for a sample held on `valid_in` appear one clock later with `valid_out` high. On a cycle where `valid_in` is low, `valid_out` falls one clock later and the data outputs keep their values.
- R7: While `rst_n` is low, `valid_out`, `key_bit`, `helper_out` and `err_pat` are all zero.
- R8: Elaboration is rejected when N is even or smaller than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Marks a sample to evaluate |
| resp_in | input | N | Response word (enrollment or fresh readout) |
| helper_in | input | N-1 | Stored helper bits for recovery |
| valid_out | output | 1 | Outputs hold a new result |
| helper_out | output | N-1 | Helper bits derived from `resp_in` |
| key_bit | output | 1 | Recovered key bit |
| err_pat | output | N | Estimated flip pattern of `resp_in` |

## Verification
The assertions check four things on every cycle: the helper mapping, the valid timing and hold behaviour, that the error pattern never weighs more than (N-1)/2, and that the corrected readout forms a code word whose common value is the key bit. They do not check whether the decoded word is the one that was enrolled. Only the bench can show that, because it knows the original word. It sweeps every 7-bit enrolled word against every 7-bit flip pattern and checks correct recovery up to three flips and the complementary decision from four flips up. It also covers reset and output hold.

// File: rtl/rep_sketch_pkg.sv
package rep_sketch_pkg;

   // Majority threshold for an odd code length
   function automatic int unsigned maj_thresh(input int unsigned n);
      return (n + 1) / 2;
   endfunction

   // Width needed to count 0..n ones
   function automatic int unsigned cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rep_weight.sv
module rep_weight #(
   parameter int unsigned W  = 7,
   localparam int unsigned CW = rep_sketch_pkg::cnt_width(W)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] ones
);
   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++) begin
         ones = ones + CW'(vec[i]);
      end
   end
endmodule

// File: rtl/rep_helper_gen.sv
module rep_helper_gen #(
   parameter int unsigned N = 7
) (
   input  logic [N-1:0] word,
   output logic [N-2:0] hlp
);
   for (genvar g = 0; g < N - 1; g++) begin : g_hlp
      assign hlp[g] = word[0] ^ word[g+1];
   end
endmodule

// File: rtl/rep_recover.sv
module rep_recover #(
   parameter int unsigned N = 7
) (
   input  logic [N-1:0] rd,
   input  logic [N-2:0] hlp,
   output logic         key,
   output logic [N-1:0] err
);
   import rep_sketch_pkg::*;

   localparam int unsigned CE = cnt_width(N);
   localparam int unsigned CS = cnt_width(N - 1);
   localparam logic [CE-1:0] THR_E = CE'(maj_thresh(N));
   localparam logic [CS-1:0] THR_S = CS'(maj_thresh(N));

   logic [N-1:0]  est;
   logic [N-2:0]  syn;
   logic [CE-1:0] est_ones;
   logic [CS-1:0] syn_ones;
   logic          e0;

   assign est[0] = rd[0];
   for (genvar g = 1; g < N; g++) begin : g_est
      assign est[g]   = rd[g] ^ hlp[g-1];
      assign syn[g-1] = rd[0] ^ est[g];
   end

   rep_weight #(.W(N)) u_est_w (
      .vec  (est),
      .ones (est_ones)
   );

   rep_weight #(.W(N - 1)) u_syn_w (
      .vec  (syn),
      .ones (syn_ones)
   );

   assign key = (est_ones >= THR_E);
   assign e0  = (syn_ones >= THR_S);

   assign err[0] = e0;
   for (genvar g = 1; g < N; g++) begin : g_err
      assign err[g] = e0 ^ syn[g-1];
   end
endmodule

// File: rtl/rep_sketch.sv
module rep_sketch #(
   parameter int unsigned N       = 7,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_in,
   input  logic [N-1:0] resp_in,
   input  logic [N-2:0] helper_in,
   output logic         valid_out,
   output logic [N-2:0] helper_out,
   output logic         key_bit,
   output logic [N-1:0] err_pat
);
   // R8: code length must be odd and at least 3
   if ((N % 2) == 0 || N < 3) begin : g_bad_n
      $error("rep_sketch: N must be odd and >= 3");
   end

   logic [N-2:0] hlp_c;
   logic         key_c;
   logic [N-1:0] err_c;

   rep_helper_gen #(.N(N)) u_gen (
      .word (resp_in),
      .hlp  (hlp_c)
   );

   rep_recover #(.N(N)) u_rec (
      .rd   (resp_in),
      .hlp  (helper_in),
      .key  (key_c),
      .err  (err_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_out  <= 1'b0;
            helper_out <= '0;
            key_bit    <= 1'b0;
            err_pat    <= '0;
         end else begin
            valid_out <= valid_in;
            if (valid_in) begin
               helper_out <= hlp_c;
               key_bit    <= key_c;
               err_pat    <= err_c;
            end
         end
      end
   end else begin : g_comb
      assign valid_out  = valid_in & rst_n;
      assign helper_out = rst_n ? hlp_c : '0;
      assign key_bit    = rst_n & key_c;
      assign err_pat    = rst_n ? err_c : '0;
   end
endmodule

// File: rtl/rep_sketch_chk.sv
module rep_sketch_chk #(
   parameter int unsigned N       = 7,
   parameter bit          REG_OUT = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         valid_in,
   input logic [N-1:0] resp_in,
   input logic [N-2:0] helper_in,
   input logic         valid_out,
   input logic [N-2:0] helper_out,
   input logic         key_bit,
   input logic [N-1:0] err_pat
);
   localparam int unsigned T = (N - 1) / 2;

   if (REG_OUT) begin : g_chk
      a_r6_valid_rise : assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> valid_out);
      a_r6_valid_fall : assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> !valid_out);
      a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
         !valid_in |=> ($stable(helper_out) && $stable(key_bit) && $stable(err_pat)));
      a_r1_helper : assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> (helper_out == ($past(resp_in[N-1:1]) ^ {(N-1){$past(resp_in[0])}})));
      a_r5_codeword : assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> (((err_pat ^ $past(resp_in)) ^ {$past(helper_in), 1'b0}) == {N{key_bit}}));
      a_r3_weight : assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> ($countones(err_pat) <= T));
      a_r7_reset : assert property (@(posedge clk)
         !rst_n |=> (!valid_out && !key_bit && (err_pat == '0) && (helper_out == '0)));
   end
endmodule

bind rep_sketch rep_sketch_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_in   (valid_in),
   .resp_in    (resp_in),
   .helper_in  (helper_in),
   .valid_out  (valid_out),
   .helper_out (helper_out),
   .key_bit    (key_bit),
   .err_pat    (err_pat)
);

// File: tb/rep_sketch_test.sv
`timescale 1ns/1ps
module rep_sketch_test;
   localparam int N = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_in = 1'b0;
   logic [N-1:0] resp_in = '0;
   logic [N-2:0] helper_in = '0;
   logic         valid_out;
   logic [N-2:0] helper_out;
   logic         key_bit;
   logic [N-1:0] err_pat;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   rep_sketch #(.N(N), .REG_OUT(1'b1)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_in   (valid_in),
      .resp_in    (resp_in),
      .helper_in  (helper_in),
      .valid_out  (valid_out),
      .helper_out (helper_out),
      .key_bit    (key_bit),
      .err_pat    (err_pat)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [N-2:0] mk_helper(input logic [N-1:0] w);
      logic [N-2:0] h;
      for (int i = 0; i < N - 1; i++) h[i] = w[0] ^ w[i+1];
      return h;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [N-1:0] enr, flip, rd, exp_err;
      logic         exp_key;
      logic [N-2:0] last_h;
      logic         last_k;
      logic [N-1:0] last_e;

      // R7: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R7 valid_out", 32'(valid_out), 0);
      check("R7 key_bit", 32'(key_bit), 0);
      check("R7 err_pat", 32'(err_pat), 0);
      check("R7 helper_out", 32'(helper_out), 0);
      rst_n = 1'b1;

      // Exhaustive sweep: R1, R2, R3, R4, R5
      for (int m = 0; m < (1 << N); m++) begin
         for (int e = 0; e < (1 << N); e++) begin
            enr       = N'(m);
            flip      = N'(e);
            rd        = enr ^ flip;
            valid_in  = 1'b1;
            resp_in   = rd;
            helper_in = mk_helper(enr);
            if ($countones(flip) <= (N - 1) / 2) begin
               exp_err = flip;
               exp_key = enr[0];
            end else begin
               exp_err = ~flip;
               exp_key = ~enr[0];
            end
            @(posedge clk);
            @(negedge clk);
            check("R6 valid_out", 32'(valid_out), 1);
            check("R1 helper_out", 32'(helper_out), 32'(mk_helper(rd)));
            check("R2 R5 key_bit", 32'(key_bit), 32'(exp_key));
            check("R3 err_pat[0]", 32'(err_pat[0]), 32'(exp_err[0]));
            check("R4 R5 err_pat", 32'(err_pat), 32'(exp_err));
         end
      end

      // R6: outputs hold while valid_in is low
      last_h = helper_out;
      last_k = key_bit;
      last_e = err_pat;
      valid_in  = 1'b0;
      resp_in   = 7'h2A;
      helper_in = 6'h15;
      @(posedge clk);
      @(negedge clk);
      check("R6 valid_out low", 32'(valid_out), 0);
      check("R6 helper hold", 32'(helper_out), 32'(last_h));
      check("R6 key hold", 32'(key_bit), 32'(last_k));
      check("R6 err hold", 32'(err_pat), 32'(last_e));

      // R7: reset again clears outputs
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R7 valid_out again", 32'(valid_out), 0);
      check("R7 err_pat again", 32'(err_pat), 0);
      check("R7 helper again", 32'(helper_out), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule